// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block searches for a pair of PLL settings: a reference pre-divider N and a feedback multiplier M. Together they must produce an oscillator (DCO) frequency inside a requested window and respect the limits of one PLL instance.

The block takes the following inputs:
- the reference frequency;
- the lowest and highest wanted DCO frequency;
- the allowed range of the internal (post-pre-divider) frequency;
- the highest DCO frequency the hardware supports;
- the largest N and the largest M the hardware supports.

All frequencies are unsigned integers in one common unit.

A start pulse launches the search. The engine derives the N bounds and, for each N, the internal frequency and the M bounds. It gets all of these from one multi-cycle restoring divider, using floor and ceiling division. It then offers each legal candidate to a consumer, one at a time.

A candidate is the tuple N, M, internal frequency and DCO = 2·M·internal frequency. The consumer answers each candidate with accept or reject. The search ends at the first accepted candidate, reporting found. If every legal pair is rejected, it ends reporting not found.

The configuration inputs must be held stable while busy is high. All hardware limits and both internal-frequency limits must be non-zero.

Top module: `pll_nm_search`

## Requirements
- R1: N runs from max(1, ceil(ref / fint_max)) up to min(floor(ref / fint_min), n_max), inclusive.
- R2: For each N the offered internal frequency is floor(ref / N).
- R3: For each N, M starts at max(1, ceil(ceil(dco_min / fint) / 2)).
- R4: For each N, M ends at the smallest of floor(floor(dco_max / fint) / 2), floor(floor(dco_hw_max / fint) / 2) and m_max.
- R5: The offered DCO frequency equals 2 × M × internal frequency.
- R6: A dco_max of zero is treated as all ones, so it sets no upper bound.
- R7: Candidates appear with N as the outer loop and M as the inner loop, both ascending.
- R8: While cand_valid is high and neither accept nor reject is high, the candidate outputs hold their values.
- R9: Accept (which takes priority over reject) ends the search. done pulses, and found is 1 and stays 1 until the next start.
- R10: Rejecting the last legal candidate ends the search with a done pulse and found 0.
- R11: An empty N range, or an empty M range for a given N, produces no candidate for that range.
- R12: busy rises on the cycle after start and falls with the done pulse. done lasts one cycle. cand_valid is only high while busy. A start while busy has no effect.
- R13: After reset, busy, done, found and cand_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a search when idle |
| ref_freq | input | FW | Reference frequency |
| fint_min | input | FW | Lowest allowed internal frequency (non-zero) |
| fint_max | input | FW | Highest allowed internal frequency (non-zero) |
| dco_min | input | FW | Lowest wanted DCO frequency |
| dco_max | input | FW | Highest wanted DCO frequency, 0 = unbounded |
| dco_hw_max | input | FW | Hardware DCO ceiling |
| n_max | input | NW | Hardware maximum of N |
| m_max | input | MW | Hardware maximum of M |
| accept | input | 1 | Takes the shown candidate and ends the search |
| reject | input | 1 | Discards the shown candidate and advances |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Last search ended on an accepted candidate |
| cand_valid | output | 1 | A candidate is on the outputs |
| cand_n | output | NW | Candidate pre-divider |
| cand_m | output | MW | Candidate multiplier |
| cand_fint | output | FW | Candidate internal frequency |
| cand_dco | output | FW | Candidate DCO frequency |

## Verification
The hardest situation to reach from the ports is an N whose M range is empty. The bench still has to see that the walk moves on silently, with no candidate and no hang.

One stimulus vector picks a tight hardware DCO ceiling, so every N yields an M stop of zero. Another picks internal-frequency limits that leave N itself empty. Both must end with found low and no candidate shown.

A further vector pulses start in the middle of a search. The bench then confirms that the candidate sequence matches its own model unchanged.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for start
      ST_NLO,    // ref / fint_max
      ST_NHI,    // ref / fint_min
      ST_FINT,   // ref / n
      ST_MLO,    // dco_min / fint
      ST_MREQ,   // requested ceiling / fint
      ST_MHW,    // hardware ceiling / fint
      ST_SHOW    // candidate offered
   } srch_state_t;
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  q_r, r_r, d_r;
   logic [CW-1:0] cnt;
   logic          done_r;
   logic [W:0]    shifted, trial;

   assign shifted = {r_r, q_r[W-1]};
   assign trial   = shifted - {1'b0, d_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         d_r    <= '0;
         cnt    <= '0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (go) begin
            q_r <= dividend;
            r_r <= '0;
            d_r <= divisor;
            cnt <= CW'(W);
         end else if (cnt != '0) begin
            if (!trial[W]) begin
               r_r <= trial[W-1:0];
               q_r <= {q_r[W-2:0], 1'b1};
            end else begin
               r_r <= shifted[W-1:0];
               q_r <= {q_r[W-2:0], 1'b0};
            end
            cnt    <= cnt - 1'b1;
            done_r <= (cnt == CW'(1));
         end
      end
   end

   assign done = done_r;
   assign quo  = q_r;
   assign rem  = r_r;

   // R2: a finished division leaves a remainder below the divisor
   assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_r && d_r != '0) |-> (r_r < d_r));
   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |=> !done_r);
endmodule

// File: rtl/pll_srch_minsel.sv
module pll_srch_minsel #(
   parameter int W = 32,
   parameter int K = 3
) (
   input  logic [K-1:0][W-1:0] vals,
   output logic [W-1:0]        lo
);
   logic [W-1:0] acc [K];

   assign acc[0] = vals[0];
   for (genvar i = 1; i < K; i++) begin : g_reduce
      assign acc[i] = (vals[i] < acc[i-1]) ? vals[i] : acc[i-1];
   end
   assign lo = acc[K-1];

   if (K < 1) begin : g_bad_k
      $error("pll_srch_minsel needs K >= 1");
   end
endmodule

// File: rtl/pll_nm_search.sv
module pll_nm_search
   import pll_srch_pkg::*;
#(
   parameter int FW = 32,
   parameter int NW = 8,
   parameter int MW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] ref_freq,
   input  logic [FW-1:0] fint_min,
   input  logic [FW-1:0] fint_max,
   input  logic [FW-1:0] dco_min,
   input  logic [FW-1:0] dco_max,
   input  logic [FW-1:0] dco_hw_max,
   input  logic [NW-1:0] n_max,
   input  logic [MW-1:0] m_max,
   input  logic          accept,
   input  logic          reject,
   output logic          busy,
   output logic          done,
   output logic          found,
   output logic          cand_valid,
   output logic [NW-1:0] cand_n,
   output logic [MW-1:0] cand_m,
   output logic [FW-1:0] cand_fint,
   output logic [FW-1:0] cand_dco
);
   localparam logic [FW-1:0] ONE = FW'(1);

   if (NW > FW || MW > FW || FW < 4) begin : g_bad_width
      $error("pll_nm_search: NW and MW must not exceed FW, FW >= 4");
   end

   srch_state_t   st;
   logic          issue, busy_r, done_r, found_r;
   logic [FW-1:0] n_r, n_stop_r, m_r, m_stop_r, m_req_r, fint_r;

   // divider operand selection
   logic [FW-1:0] dvd, dvs, quo, rem, dmax_eff;
   logic          div_done;

   assign dmax_eff = (dco_max == '0) ? '1 : dco_max;

   always_comb begin
      dvd = '0;
      dvs = ONE;
      unique case (st)
         ST_NLO:  begin dvd = ref_freq;   dvs = fint_max; end
         ST_NHI:  begin dvd = ref_freq;   dvs = fint_min; end
         ST_FINT: begin dvd = ref_freq;   dvs = n_r;      end
         ST_MLO:  begin dvd = dco_min;    dvs = fint_r;   end
         ST_MREQ: begin dvd = dmax_eff;   dvs = fint_r;   end
         ST_MHW:  begin dvd = dco_hw_max; dvs = fint_r;   end
         default: ;
      endcase
   end

   pll_srch_div #(.W(FW)) u_div (
      .clk(clk), .rst_n(rst_n), .go(issue), .dividend(dvd), .divisor(dvs),
      .done(div_done), .quo(quo), .rem(rem)
   );

   // ceiling forms of the current quotient
   logic [FW:0]   ceil_q, half_up;
   logic [FW-1:0] n_start_v, m_start_v, n_stop_v, m_stop_v;

   assign ceil_q    = {1'b0, quo} + {{FW{1'b0}}, (rem != '0)};
   assign half_up   = (ceil_q + (FW+1)'(1)) >> 1;
   assign n_start_v = (ceil_q[FW-1:0] == '0) ? ONE : ceil_q[FW-1:0];
   assign m_start_v = (half_up[FW-1:0] == '0) ? ONE : half_up[FW-1:0];

   pll_srch_minsel #(.W(FW), .K(2)) u_nstop (
      .vals({FW'(n_max), quo}), .lo(n_stop_v)
   );
   pll_srch_minsel #(.W(FW), .K(3)) u_mstop (
      .vals({FW'(m_max), quo >> 1, m_req_r}), .lo(m_stop_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         issue    <= 1'b0;
         busy_r   <= 1'b0;
         done_r   <= 1'b0;
         found_r  <= 1'b0;
         n_r      <= ONE;
         n_stop_r <= '0;
         m_r      <= ONE;
         m_stop_r <= '0;
         m_req_r  <= '0;
         fint_r   <= ONE;
      end else begin
         issue  <= 1'b0;
         done_r <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               busy_r  <= 1'b1;
               found_r <= 1'b0;
               st      <= ST_NLO;
               issue   <= 1'b1;
            end
            ST_NLO: if (div_done) begin
               n_r   <= n_start_v;
               st    <= ST_NHI;
               issue <= 1'b1;
            end
            ST_NHI: if (div_done) begin
               n_stop_r <= n_stop_v;
               if (n_r > n_stop_v) begin
                  st     <= ST_IDLE;
                  busy_r <= 1'b0;
                  done_r <= 1'b1;
               end else begin
                  st    <= ST_FINT;
                  issue <= 1'b1;
               end
            end
            ST_FINT: if (div_done) begin
               fint_r <= quo;
               st     <= ST_MLO;
               issue  <= 1'b1;
            end
            ST_MLO: if (div_done) begin
               m_r   <= m_start_v;
               st    <= ST_MREQ;
               issue <= 1'b1;
            end
            ST_MREQ: if (div_done) begin
               m_req_r <= quo >> 1;
               st      <= ST_MHW;
               issue   <= 1'b1;
            end
            ST_MHW: if (div_done) begin
               m_stop_r <= m_stop_v;
               if (m_r <= m_stop_v) begin
                  st <= ST_SHOW;
               end else if (n_r == n_stop_r) begin
                  st     <= ST_IDLE;
                  busy_r <= 1'b0;
                  done_r <= 1'b1;
               end else begin
                  n_r   <= n_r + ONE;
                  st    <= ST_FINT;
                  issue <= 1'b1;
               end
            end
            ST_SHOW: begin
               if (accept) begin
                  st      <= ST_IDLE;
                  busy_r  <= 1'b0;
                  done_r  <= 1'b1;
                  found_r <= 1'b1;
               end else if (reject) begin
                  if (m_r != m_stop_r) begin
                     m_r <= m_r + ONE;
                  end else if (n_r == n_stop_r) begin
                     st     <= ST_IDLE;
                     busy_r <= 1'b0;
                     done_r <= 1'b1;
                  end else begin
                     n_r   <= n_r + ONE;
                     st    <= ST_FINT;
                     issue <= 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = busy_r;
   assign done       = done_r;
   assign found      = found_r;
   assign cand_valid = (st == ST_SHOW);
   assign cand_n     = n_r[NW-1:0];
   assign cand_m     = m_r[MW-1:0];
   assign cand_fint  = fint_r;
   assign cand_dco   = (m_r * fint_r) << 1;

   // R8: an unanswered candidate stays put
   assert_cand_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !accept && !reject) |=>
         (cand_valid && $stable(cand_n) && $stable(cand_m) && $stable(cand_fint)));
   // R12: candidates only during a search, done is a single pulse
   assert_valid_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> busy);
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: found only appears together with the end of a search
   assert_found_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> done);
   // R1: shown N lies inside hardware limits
   assert_n_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (cand_n != '0 && cand_n <= n_max));
   // R4: shown M never exceeds the hardware maximum
   assert_m_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (cand_m != '0 && cand_m <= m_max));
endmodule

// File: tb/pll_nm_search_test.sv
module pll_nm_search_test;
   localparam int FW = 32;
   localparam int NW = 8;
   localparam int MW = 12;
   localparam int NV = 6;
   localparam int MAXC = 64;

   // vectors: V0 R6 unbounded max, V1 R3 R4 reject all + start while busy,
   // V2 R11 empty N, V3 R11 empty M ranges, V4 accept first, V5 accept last
   localparam longint T_REF  [NV] = '{100, 100, 100, 1000, 27, 100};
   localparam longint T_FMIN [NV] = '{20, 30, 60, 10, 1, 30};
   localparam longint T_FMAX [NV] = '{50, 50, 70, 500, 27, 50};
   localparam longint T_DMIN [NV] = '{400, 300, 300, 0, 1, 300};
   localparam longint T_DMAX [NV] = '{0, 400, 400, 0, 0, 400};
   localparam longint T_HW   [NV] = '{1000, 1000, 1000, 100, 200, 1000};
   localparam longint T_NMAX [NV] = '{8, 8, 8, 3, 4, 8};
   localparam longint T_MMAX [NV] = '{20, 20, 20, 2, 3, 20};
   localparam int     T_ACC  [NV] = '{2, -1, -1, -1, 0, 3};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, accept = 1'b0, reject = 1'b0;
   logic [FW-1:0] ref_freq = '0, fint_min = 1, fint_max = 1, dco_min = '0, dco_max = '0, dco_hw_max = 1;
   logic [NW-1:0] n_max = 1;
   logic [MW-1:0] m_max = 1;
   logic busy, done, found, cand_valid;
   logic [NW-1:0] cand_n;
   logic [MW-1:0] cand_m;
   logic [FW-1:0] cand_fint, cand_dco;

   always #5 clk = ~clk;

   pll_nm_search #(.FW(FW), .NW(NW), .MW(MW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_freq(ref_freq),
      .fint_min(fint_min), .fint_max(fint_max), .dco_min(dco_min), .dco_max(dco_max),
      .dco_hw_max(dco_hw_max), .n_max(n_max), .m_max(m_max), .accept(accept),
      .reject(reject), .busy(busy), .done(done), .found(found), .cand_valid(cand_valid),
      .cand_n(cand_n), .cand_m(cand_m), .cand_fint(cand_fint), .cand_dco(cand_dco)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   longint e_n [MAXC], e_m [MAXC], e_f [MAXC], e_d [MAXC];
   int e_cnt;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // expected candidate list from the requirement formulas
   task automatic build_expect(input int v);
      longint ns, ne, f, ms, me, dm, t;
      e_cnt = 0;
      ns = (T_REF[v] + T_FMAX[v] - 1) / T_FMAX[v];
      if (ns < 1) ns = 1;
      ne = T_REF[v] / T_FMIN[v];
      if (ne > T_NMAX[v]) ne = T_NMAX[v];
      for (longint n = ns; n <= ne; n++) begin
         f  = T_REF[v] / n;
         ms = (((T_DMIN[v] + f - 1) / f) + 1) / 2;
         if (ms < 1) ms = 1;
         dm = (T_DMAX[v] == 0) ? 64'hFFFF_FFFF : T_DMAX[v];
         me = dm / f / 2;
         t  = T_HW[v] / f / 2;
         if (t < me) me = t;
         if (T_MMAX[v] < me) me = T_MMAX[v];
         for (longint m = ms; m <= me; m++) begin
            if (e_cnt < MAXC) begin
               e_n[e_cnt] = n; e_m[e_cnt] = m; e_f[e_cnt] = f; e_d[e_cnt] = 2 * m * f;
            end
            e_cnt++;
         end
      end
   endtask

   task automatic run_vec(input int v);
      int k, guard, aix, shown_exp;
      bit got_done, exp_found;
      longint hn, hm;
      build_expect(v);
      aix = T_ACC[v];
      exp_found = (aix >= 0) && (aix < e_cnt);
      shown_exp = exp_found ? aix + 1 : e_cnt;
      @(negedge clk);
      ref_freq = FW'(T_REF[v]); fint_min = FW'(T_FMIN[v]); fint_max = FW'(T_FMAX[v]);
      dco_min = FW'(T_DMIN[v]); dco_max = FW'(T_DMAX[v]); dco_hw_max = FW'(T_HW[v]);
      n_max = NW'(T_NMAX[v]); m_max = MW'(T_MMAX[v]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R12 busy after start", longint'(busy), 1);
      k = 0; guard = 0; got_done = 0;
      while (!got_done && guard < 20000) begin
         @(negedge clk);
         guard++;
         accept = 1'b0; reject = 1'b0;
         if (v == 1 && guard == 3) begin
            start = 1'b1;   // R12: ignored while busy
            @(negedge clk);
            start = 1'b0;
         end
         if (done) begin
            got_done = 1;
         end else if (cand_valid) begin
            if (k < e_cnt && k < MAXC) begin
               chk(longint'(cand_n) == e_n[k], "R1 R7 cand_n", longint'(cand_n), e_n[k]);
               chk(longint'(cand_m) == e_m[k], "R3 R4 R7 cand_m", longint'(cand_m), e_m[k]);
               chk(longint'(cand_fint) == e_f[k], "R2 cand_fint", longint'(cand_fint), e_f[k]);
               chk(longint'(cand_dco) == e_d[k], "R5 R6 cand_dco", longint'(cand_dco), e_d[k]);
            end else begin
               chk(1'b0, "R11 extra candidate", longint'(k), longint'(e_cnt));
            end
            if (k % 2 == 1) begin
               hn = longint'(cand_n); hm = longint'(cand_m);
               repeat (3) @(negedge clk);
               chk(cand_valid && longint'(cand_n) == hn && longint'(cand_m) == hm,
                   "R8 candidate hold", longint'(cand_m), hm);
            end
            if (k == aix) accept = 1'b1;
            else          reject = 1'b1;
            k++;
         end
      end
      if (!got_done) chk(1'b0, "R12 watchdog no done", longint'(guard), 20000);
      chk(found == exp_found, "R9 R10 found", longint'(found), longint'(exp_found));
      chk(k == shown_exp, "R10 R11 candidate count", longint'(k), longint'(shown_exp));
      chk(busy == 1'b0, "R12 busy low at done", longint'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R12 done one cycle", longint'(done), 0);
      chk(found == exp_found, "R9 found held", longint'(found), longint'(exp_found));
   endtask

   initial begin
      #(200000 * 10);
      chk(1'b0, "R12 global watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !found && !cand_valid, "R13 reset state",
          longint'({busy, done, found, cand_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cand_valid, "R13 idle after reset", longint'({busy, cand_valid}), 0);
      for (int v = 0; v < NV; v++) run_vec(v);
      summary();
   end
endmodule